// File: doc/BRIEF.md
# Hint-Driven High Part Adjuster

This block takes the corrected high part of a value that was split into a high part and a remainder, together with the remainder itself, the sign flag of that split and a one-bit hint. It returns an adjusted high value that lies on a ring of `RING` values (16 by default). When the hint is clear, the high part passes through unchanged. When the hint is set, the high part moves one step around the ring.

The remainder picks the direction of the step. A nonzero remainder in the lower half (sign flag clear) steps up. Every other case steps down, and that includes a remainder of zero. Stepping up from the top value wraps to 0, and stepping down from 0 wraps to the top value.

A caller-supplied tag travels with each operand. By default the result and the tag are registered when `in_valid` is high, and they appear one cycle later together with `out_valid`. The parameter `REG_OUT` = 0 turns the block into pure combinational logic.

Top module: `hint_adjust_top`

## Requirements
- R1: With `hint` = 0, `out_w1` equals the `r1c` that was presented.
- R2: The step direction is up exactly when `r0` is nonzero and `neg` is 0. In every other case it is down.
- R3: With `hint` = 1 and direction up, `out_w1` is `r1c`+1. The exception is `r1c` = `RING`-1 (15), which gives 0.
- R4: With `hint` = 1 and direction down, `out_w1` is `r1c`-1. The exception is `r1c` = 0, which gives `RING`-1 (15).
- R5: A zero remainder with `hint` = 1 always steps down, whatever the value of `neg`. For example, `r1c` = 0 and `r0` = 0 give 15.
- R6: With `REG_OUT` = 1, `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. `out_tag` carries the `tag` of that same operand.
- R7: While reset is held, and in the cycles just after it, `out_valid` is 0.
- R8: When `in_valid` is low, `out_w1` and `out_tag` keep their previous values.
- R9: For any `r1c` below `RING`, a valid `out_w1` is always below `RING`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operand valid; acts as the capture enable |
| r1c | input | HIGH_W (5) | Corrected high part, below RING |
| r0 | input | REM_W (19) | Remainder of the split |
| neg | input | 1 | Remainder lies in the upper half |
| hint | input | 1 | Hint bit; 1 requests a step |
| tag | input | TAG_W (8) | Caller tag (for example an index) |
| out_valid | output | 1 | Result valid |
| out_w1 | output | HIGH_W (5) | Adjusted high value |
| out_tag | output | TAG_W (8) | Tag that goes with the result |

## Verification
The bench concentrates on the two wrap points: stepping up from 15 and stepping down from 0. An adjuster that dropped the wrap would emit 16 or 31 there, and one that took the modulus at the output width would emit 31 instead of 15.

The bench also goes after the direction boundary. It uses remainders of 0, 1, half-range and half-range+1, plus `neg` values that disagree with the remainder. A design that decided the direction from `neg` alone would step up on a zero remainder.

Finally, the bench changes the inputs while `in_valid` is low. A missing capture enable would let those changes reach the outputs.

// File: rtl/hadj_pkg.sv
package hadj_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } hadj_dir_e;
endpackage

// File: rtl/hadj_rst_sync.sv
module hadj_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/hadj_dir.sv
module hadj_dir #(
  parameter int REM_W = 19
) (
  input  logic [REM_W-1:0]     r0,
  input  logic                 neg,
  output hadj_pkg::hadj_dir_e  dir
);
  logic rem_nonzero;

  // Up only for a nonzero remainder in the lower half; zero remainder goes down.
  always_comb begin
    rem_nonzero = |r0;
    dir = (rem_nonzero && !neg) ? hadj_pkg::DIR_UP : hadj_pkg::DIR_DOWN;
  end
endmodule

// File: rtl/hadj_step.sv
module hadj_step #(
  parameter int HIGH_W = 5,
  parameter int RING   = 16
) (
  input  logic [HIGH_W-1:0]    r1c,
  input  logic                 hint,
  input  hadj_pkg::hadj_dir_e  dir,
  output logic [HIGH_W-1:0]    w1
);
  localparam logic [HIGH_W-1:0] TOP_VAL = HIGH_W'(RING - 1);
  localparam logic [HIGH_W-1:0] ONE_VAL = HIGH_W'(1);

  logic [HIGH_W-1:0] up_val;
  logic [HIGH_W-1:0] down_val;

  always_comb begin
    up_val   = (r1c == TOP_VAL) ? '0 : r1c + ONE_VAL;
    down_val = (r1c == '0) ? TOP_VAL : r1c - ONE_VAL;
    if (!hint)                         w1 = r1c;
    else if (dir == hadj_pkg::DIR_UP)  w1 = up_val;
    else                               w1 = down_val;
  end
endmodule

// File: rtl/hadj_oreg.sv
module hadj_oreg #(
  parameter int  HIGH_W  = 5,
  parameter int  TAG_W   = 8,
  parameter bit  REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              in_valid,
  input  logic [HIGH_W-1:0] w1_d,
  input  logic [TAG_W-1:0]  tag_d,
  output logic              out_valid,
  output logic [HIGH_W-1:0] out_w1,
  output logic [TAG_W-1:0]  out_tag
);
  generate
    if (REG_OUT) begin : g_reg
      logic              vld_q, vld_n;
      logic [HIGH_W-1:0] w1_q, w1_n;
      logic [TAG_W-1:0]  tag_q, tag_n;

      always_comb begin
        vld_n = in_valid;
        w1_n  = w1_q;
        tag_n = tag_q;
        if (in_valid) begin
          w1_n  = w1_d;
          tag_n = tag_d;
        end
      end

      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) begin
          vld_q <= 1'b0;
          w1_q  <= '0;
          tag_q <= '0;
        end else begin
          vld_q <= vld_n;
          w1_q  <= w1_n;
          tag_q <= tag_n;
        end
      end

      assign out_valid = vld_q;
      assign out_w1    = w1_q;
      assign out_tag   = tag_q;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_sync_n;
      assign out_valid  = in_valid;
      assign out_w1     = w1_d;
      assign out_tag    = tag_d;
    end
  endgenerate
endmodule

// File: rtl/hint_adjust_top.sv
module hint_adjust_top #(
  parameter int HIGH_W  = 5,
  parameter int RING    = 16,
  parameter int REM_W   = 19,
  parameter int TAG_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [HIGH_W-1:0] r1c,
  input  logic [REM_W-1:0]  r0,
  input  logic              neg,
  input  logic              hint,
  input  logic [TAG_W-1:0]  tag,
  output logic              out_valid,
  output logic [HIGH_W-1:0] out_w1,
  output logic [TAG_W-1:0]  out_tag
);
  logic                 rst_sync_n;
  hadj_pkg::hadj_dir_e  step_dir;
  logic [HIGH_W-1:0]    w1_next;

  hadj_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hadj_dir #(.REM_W(REM_W)) u_dir (
    .r0  (r0),
    .neg (neg),
    .dir (step_dir)
  );

  hadj_step #(.HIGH_W(HIGH_W), .RING(RING)) u_step (
    .r1c  (r1c),
    .hint (hint),
    .dir  (step_dir),
    .w1   (w1_next)
  );

  hadj_oreg #(.HIGH_W(HIGH_W), .TAG_W(TAG_W), .REG_OUT(REG_OUT)) u_oreg (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .in_valid   (in_valid),
    .w1_d       (w1_next),
    .tag_d      (tag),
    .out_valid  (out_valid),
    .out_w1     (out_w1),
    .out_tag    (out_tag)
  );
endmodule

// File: rtl/hadj_chk.sv
module hadj_chk #(
  parameter int HIGH_W  = 5,
  parameter int RING    = 16,
  parameter int REM_W   = 19,
  parameter int TAG_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              in_valid,
  input logic [HIGH_W-1:0] r1c,
  input logic [REM_W-1:0]  r0,
  input logic              neg,
  input logic              hint,
  input logic [TAG_W-1:0]  tag,
  input logic              out_valid,
  input logic [HIGH_W-1:0] out_w1,
  input logic [TAG_W-1:0]  out_tag
);
  localparam logic [HIGH_W-1:0] TOP_VAL = HIGH_W'(RING - 1);

  generate
    if (REG_OUT) begin : g_seq
      AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_ok)
        (in_valid && !hint) |=> (out_w1 == $past(r1c)));  // R1
      AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_ok)
        (in_valid && hint && (r0 != '0) && !neg && (r1c != TOP_VAL)) |=> (out_w1 == HIGH_W'($past(r1c) + 1'b1)));  // R3
      AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_ok)
        (in_valid && hint && (r0 != '0) && !neg && (r1c == TOP_VAL)) |=> (out_w1 == '0));  // R3
      AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_ok)
        (in_valid && hint && (neg || (r0 == '0)) && (r1c == '0)) |=> (out_w1 == TOP_VAL));  // R4
      AST_ZERO_REM_DOWN: assert property (@(posedge clk) disable iff (!rst_ok)
        (in_valid && hint && (r0 == '0) && (r1c != '0)) |=> (out_w1 == HIGH_W'($past(r1c) - 1'b1)));  // R5
      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ok)
        in_valid |=> (out_valid && (out_tag == $past(tag))));  // R6
      AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_ok)
        !in_valid |=> !out_valid);  // R6
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
        !in_valid |=> ($stable(out_w1) && $stable(out_tag)));  // R8
      AST_IN_RING: assert property (@(posedge clk) disable iff (!rst_ok)
        (in_valid && (r1c <= TOP_VAL)) |=> (out_w1 <= TOP_VAL));  // R9
    end
  endgenerate

  always_comb begin
    if (!rst_ok && REG_OUT) AST_RESET_IDLE: assert (!out_valid);  // R7
  end
endmodule

bind hint_adjust_top hadj_chk #(
  .HIGH_W(HIGH_W), .RING(RING), .REM_W(REM_W), .TAG_W(TAG_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .in_valid  (in_valid),
  .r1c       (r1c),
  .r0        (r0),
  .neg       (neg),
  .hint      (hint),
  .tag       (tag),
  .out_valid (out_valid),
  .out_w1    (out_w1),
  .out_tag   (out_tag)
);

// File: tb/hint_adjust_top_tb.sv
module hint_adjust_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HIGH_W = 5;
  localparam int RING   = 16;
  localparam int REM_W  = 19;
  localparam int TAG_W  = 8;
  localparam int ALPHA  = 523776;
  localparam int HALF   = ALPHA / 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [HIGH_W-1:0] r1c;
  logic [REM_W-1:0]  r0;
  logic              neg;
  logic              hint;
  logic [TAG_W-1:0]  tag;
  logic              out_valid;
  logic [HIGH_W-1:0] out_w1;
  logic [TAG_W-1:0]  out_tag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hint_adjust_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .r1c(r1c), .r0(r0),
    .neg(neg), .hint(hint), .tag(tag), .out_valid(out_valid),
    .out_w1(out_w1), .out_tag(out_tag)
  );

  function automatic int model(int hi, int rem, bit ng, bit h);
    bit up;
    up = (rem != 0) && !ng;             // R2
    if (!h) return hi;                  // R1
    if (up) return (hi == RING-1) ? 0 : hi + 1;   // R3
    return (hi == 0) ? RING-1 : hi - 1;            // R4, R5
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(int hi, int rem, bit ng, bit h, int tg, string req);
    @(negedge clk);
    in_valid = 1'b1;
    r1c = HIGH_W'(hi); r0 = REM_W'(rem); neg = ng; hint = h; tag = TAG_W'(tg);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, int'(out_w1), model(hi, rem, ng, h));
    check("R6 valid", int'(out_valid), 1);
    check("R6 tag", int'(out_tag), tg & 8'hff);
    check("R9 range", int'(out_w1 < HIGH_W'(RING)), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int rems[5];
    int seed;
    int last_w1;
    int last_tag;
    rems = '{0, 1, HALF, HALF + 1, ALPHA - 1};
    seed = 32'h1a2b3c;
    void'($urandom(seed));
    rst_n = 1'b0; in_valid = 1'b0; r1c = '0; r0 = '0; neg = 1'b0; hint = 1'b0; tag = '0;
    repeat (3) @(negedge clk);
    check("R7 reset valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 after release", int'(out_valid), 0);
    repeat (3) @(negedge clk);

    // Directed corners
    apply(0, 0, 1'b0, 1'b1, 8'h11, "R5 zero rem wraps to 15");
    apply(15, 5, 1'b0, 1'b1, 8'h12, "R3 wrap up to 0");
    apply(0, HALF + 1, 1'b1, 1'b1, 8'h13, "R4 wrap down");
    apply(2, 476224, 1'b1, 1'b1, 8'h14, "R4 upper half down");
    apply(7, 0, 1'b0, 1'b1, 8'h15, "R5 zero rem, neg clear");
    apply(7, 3, 1'b1, 1'b1, 8'h16, "R2 neg forces down");
    apply(9, 123, 1'b0, 1'b0, 8'h17, "R1 no hint");

    // Sweep: every high part crossed with edge remainders and both hint values
    for (int hi = 0; hi < RING; hi++)
      for (int k = 0; k < 5; k++)
        for (int h = 0; h < 2; h++)
          apply(hi, rems[k], bit'(rems[k] > HALF), bit'(h), hi*10 + k,
                h ? "R3/R4 sweep step" : "R1 sweep pass");

    // Hold while idle
    last_w1 = int'(out_w1); last_tag = int'(out_tag);
    @(negedge clk);
    r1c = 5'd3; r0 = 19'd9; hint = 1'b1; tag = 8'hee;
    @(negedge clk);
    check("R8 hold w1", int'(out_w1), last_w1);
    check("R8 hold tag", int'(out_tag), last_tag);
    check("R6 idle valid low", int'(out_valid), 0);

    // Random operands with independent neg
    for (int i = 0; i < 300; i++) begin
      int hi, rem;
      hi  = int'($urandom % RING);
      rem = int'($urandom % ALPHA);
      if (($urandom % 4) == 0) rem = 0;
      apply(hi, rem, bit'($urandom % 2), bit'($urandom % 2), int'($urandom % 256), "R2 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule